// File: doc/BRIEF.md
# Reset Qualifier and Low-Power State Controller

This block sits next to an 8-bit microcontroller core and owns three things the core cannot manage for itself. It filters the raw reset pin so that only a pulse of at least 24 oscillator periods reaches the core. It captures the level of the external-access strap while that reset is in force, which fixes where instructions are fetched from until the next reset. It also runs the two low-power states: idle, which freezes the core but leaves the peripherals clocked, and power-down, which turns the oscillator off.

The core's power-control register supplies two request bits. These are acted on only when the core signals that the current instruction has completed. Idle is left on any pending enabled interrupt. Power-down is left only through a hardware reset. While either state is active, the block forces the external bus strobes high and decides whether port 0 floats. When a state ends, the block asks the power-control register to clear its request bits. A separate active-low power-on input gives every flop its initial state and holds the core in reset until it is released.

Top module: `rstLowPowerCtrl`

## Requirements
- R1: The pin passes through a two-flop synchronizer. `coreRst` rises only after the synchronized pin has been sampled high on 24 consecutive clock edges, that is 26 edges after the pin first goes high. Any low sample restarts the count, so shorter pulses, and two short pulses split by a single low cycle, never reset the core.
- R2: `coreRst` is high while `porN` is low. After a qualified reset, `coreRst` falls on the third clock edge after the pin is seen low.
- R3: The strap level is captured on every edge while `coreRst` is high, and the last captured value is held after release. Strap changes outside reset leave `fetchExt` unchanged.
- R4: `fetchExt` is 1 when the captured strap is 0, or when `pc` is 8192 or higher. Otherwise it is 0, which selects internal program memory.
- R5: Idle is entered on the edge where `instrDone` is high together with `idleReq`. In idle, `coreClkEn` is 0 while `periphClkEn` and `oscEn` stay 1.
- R6: Idle ends on the first edge where any bit of `irqPending` is 1. `coreClkEn` returns to 1 after that edge, and `modeClear` is high for exactly the following cycle.
- R7: Power-down is entered on the edge where `instrDone` is high together with `pdReq`. It drives `oscEn`, `periphClkEn` and `coreClkEn` to 0, ignores interrupts, and ends only when `coreRst` is high.
- R8: In idle and in power-down, `aleForceHigh` and `psenForceHigh` are 1 and `port0Float` equals `fetchExt`. In normal running all three are 0.
- R9: When `idleReq` and `pdReq` are both set at the completing instruction, power-down is entered.
- R10: Request bits have no effect on a cycle where `instrDone` is 0.
- R11: A hardware reset ends either low-power state. `modeClear` is high for as long as `coreRst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstPin | input | 1 | Raw external reset pin, active high |
| extAccessPin | input | 1 | External-access strap pin |
| idleReq | input | 1 | Idle request bit from the power-control register |
| pdReq | input | 1 | Power-down request bit from the power-control register |
| instrDone | input | 1 | Core strobe: the current instruction has completed |
| irqPending | input | IRQ_W | Enabled interrupt requests |
| pc | input | PC_W | Core program counter |
| coreRst | output | 1 | Reset to the core and peripherals |
| fetchExt | output | 1 | 1 selects external program memory |
| coreClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| aleForceHigh | output | 1 | Forces the address latch enable high |
| psenForceHigh | output | 1 | Forces the program store enable high |
| port0Float | output | 1 | Puts port 0 into high impedance |
| modeClear | output | 1 | Clears the idle and power-down request bits |

## Verification
Reset qualification is exercised with pulse lengths drawn at random between 10 and 40 cycles. Directed pulses of 23 and 24 cycles and a pair of 20-cycle pulses split by one low cycle separate a correct threshold from an off-by-one or a counter that never restarts. The fetch select is tried with random program counters and with 8191 and 8192, under both strap levels, and with the strap changed both during and after reset. The mode logic runs under random streams of requests, completion strobes and interrupts, with directed cases for simultaneous requests, requests without a completion strobe, interrupts during power-down, and reset during each state.

// File: rtl/rstlpPkg.sv
package rstlpPkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } lpModeT;

  // Strobes from the mode control to the datapath
  typedef struct packed {
    logic inIdle;
    logic inPdown;
    logic wakeStb;
  } modeStrobeT;

endpackage

// File: rtl/rstlpControl.sv
module rstlpControl
  import rstlpPkg::*;
#(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             coreRst,
  input  logic             instrDone,
  input  logic             idleReq,
  input  logic             pdReq,
  input  logic [IRQ_W-1:0] irqPending,
  output modeStrobeT       strobes
);

  lpModeT mode, modeNext;
  logic   wakeQ, wakeNext;
  logic   anyIrq;

  assign anyIrq = |irqPending;

  always_comb begin
    modeNext = mode;
    wakeNext = 1'b0;
    case (mode)
      MODE_RUN: begin
        if (instrDone) begin
          if (pdReq)        modeNext = MODE_PDOWN;  // power-down wins
          else if (idleReq) modeNext = MODE_IDLE;
        end
      end
      MODE_IDLE: begin
        if (anyIrq) begin
          modeNext = MODE_RUN;
          wakeNext = 1'b1;
        end
      end
      MODE_PDOWN: modeNext = MODE_PDOWN;            // only reset leaves
      default:    modeNext = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      mode  <= MODE_RUN;
      wakeQ <= 1'b0;
    end else if (coreRst) begin
      mode  <= MODE_RUN;
      wakeQ <= 1'b0;
    end else begin
      mode  <= modeNext;
      wakeQ <= wakeNext;
    end
  end

  always_comb begin
    strobes.inIdle  = (mode == MODE_IDLE);
    strobes.inPdown = (mode == MODE_PDOWN);
    strobes.wakeStb = wakeQ;
  end

endmodule

// File: rtl/rstlpDatapath.sv
module rstlpDatapath
  import rstlpPkg::*;
#(
  parameter int RST_CYCLES    = 24,
  parameter int SYNC_STAGES   = 2,
  parameter int PC_W          = 16,
  parameter int INT_ROM_WORDS = 8192
) (
  input  logic            clk,
  input  logic            porN,
  input  logic            rstPin,
  input  logic            extAccessPin,
  input  logic [PC_W-1:0] pc,
  input  modeStrobeT      strobes,
  output logic            coreRst,
  output logic            fetchExt,
  output logic            coreClkEn,
  output logic            periphClkEn,
  output logic            oscEn,
  output logic            aleForceHigh,
  output logic            psenForceHigh,
  output logic            port0Float,
  output logic            modeClear
);

  localparam int              CNT_W     = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);
  localparam logic [PC_W:0]   ROM_LIMIT = (PC_W + 1)'(INT_ROM_WORDS);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rstSync;
  logic [CNT_W-1:0]       highCnt;
  logic                   eaLatched;
  logic                   lowPower;

  // Synchronizer chain for the raw reset pin
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rstPin};
  end
  assign rstSync = syncQ[SYNC_STAGES-1];

  // Consecutive-high counter, saturating at the last count
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                  highCnt <= '0;
    else if (!rstSync)          highCnt <= '0;
    else if (highCnt != CNT_LAST) highCnt <= highCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) coreRst <= 1'b1;
    else       coreRst <= rstSync && (highCnt == CNT_LAST);
  end

  // Strap capture: tracks the pin only while reset is in force
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)        eaLatched <= 1'b1;
    else if (coreRst) eaLatched <= extAccessPin;
  end

  assign fetchExt = !eaLatched || ({1'b0, pc} >= ROM_LIMIT);

  assign lowPower      = strobes.inIdle || strobes.inPdown;
  assign coreClkEn     = !lowPower;
  assign periphClkEn   = !strobes.inPdown;
  assign oscEn         = !strobes.inPdown;
  assign aleForceHigh  = lowPower;
  assign psenForceHigh = lowPower;
  assign port0Float    = lowPower && fetchExt;
  assign modeClear     = coreRst || strobes.wakeStb;

endmodule

// File: rtl/rstLowPowerCtrl.sv
module rstLowPowerCtrl
  import rstlpPkg::*;
#(
  parameter int RST_CYCLES    = 24,
  parameter int SYNC_STAGES   = 2,
  parameter int PC_W          = 16,
  parameter int INT_ROM_WORDS = 8192,
  parameter int IRQ_W         = 8
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstPin,
  input  logic             extAccessPin,
  input  logic             idleReq,
  input  logic             pdReq,
  input  logic             instrDone,
  input  logic [IRQ_W-1:0] irqPending,
  input  logic [PC_W-1:0]  pc,
  output logic             coreRst,
  output logic             fetchExt,
  output logic             coreClkEn,
  output logic             periphClkEn,
  output logic             oscEn,
  output logic             aleForceHigh,
  output logic             psenForceHigh,
  output logic             port0Float,
  output logic             modeClear
);

  modeStrobeT strobes;

  rstlpControl #(.IRQ_W(IRQ_W)) ctrlI (
    .clk        (clk),
    .porN       (porN),
    .coreRst    (coreRst),
    .instrDone  (instrDone),
    .idleReq    (idleReq),
    .pdReq      (pdReq),
    .irqPending (irqPending),
    .strobes    (strobes)
  );

  rstlpDatapath #(
    .RST_CYCLES    (RST_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES),
    .PC_W          (PC_W),
    .INT_ROM_WORDS (INT_ROM_WORDS)
  ) dpI (
    .clk           (clk),
    .porN          (porN),
    .rstPin        (rstPin),
    .extAccessPin  (extAccessPin),
    .pc            (pc),
    .strobes       (strobes),
    .coreRst       (coreRst),
    .fetchExt      (fetchExt),
    .coreClkEn     (coreClkEn),
    .periphClkEn   (periphClkEn),
    .oscEn         (oscEn),
    .aleForceHigh  (aleForceHigh),
    .psenForceHigh (psenForceHigh),
    .port0Float    (port0Float),
    .modeClear     (modeClear)
  );

endmodule

// File: rtl/rstlpChecker.sv
module rstlpChecker #(
  parameter int IRQ_W = 8,
  parameter int PC_W  = 16
) (
  input logic             clk,
  input logic             porN,
  input logic             rstPin,
  input logic             instrDone,
  input logic             pdReq,
  input logic [IRQ_W-1:0] irqPending,
  input logic [PC_W-1:0]  pc,
  input logic             coreRst,
  input logic             fetchExt,
  input logic             coreClkEn,
  input logic             periphClkEn,
  input logic             oscEn,
  input logic             aleForceHigh,
  input logic             psenForceHigh,
  input logic             port0Float
);

  AST_RST_FROM_PIN: assert property (@(posedge clk) disable iff (!porN)
    $rose(coreRst) |-> $past(rstPin, 3)); // R1

  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!porN)
    $fell(coreRst) |-> !$past(rstPin, 2)); // R2

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!porN)
    (!coreRst && !$past(coreRst) && $stable(pc)) |-> $stable(fetchExt)); // R3

  AST_CLK_ORDER: assert property (@(posedge clk) disable iff (!porN)
    !oscEn |-> (!periphClkEn && !coreClkEn)); // R5

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!porN)
    ($rose(coreClkEn) && oscEn && $past(oscEn)) |-> ($past(coreRst) || $past(|irqPending))); // R6

  AST_PD_EXIT: assert property (@(posedge clk) disable iff (!porN)
    $rose(oscEn) |-> $past(coreRst)); // R7

  AST_STROBE_FORCE: assert property (@(posedge clk) disable iff (!porN)
    !coreClkEn |-> (aleForceHigh && psenForceHigh && (port0Float == fetchExt))); // R8

  AST_RUN_NO_FLOAT: assert property (@(posedge clk) disable iff (!porN)
    coreClkEn |-> (!port0Float && !aleForceHigh)); // R8

  AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!porN)
    $past(instrDone && pdReq && coreClkEn && !coreRst) |-> !oscEn); // R9

endmodule

bind rstLowPowerCtrl rstlpChecker #(.IRQ_W(IRQ_W), .PC_W(PC_W)) chkI (
  .clk           (clk),
  .porN          (porN),
  .rstPin        (rstPin),
  .instrDone     (instrDone),
  .pdReq         (pdReq),
  .irqPending    (irqPending),
  .pc            (pc),
  .coreRst       (coreRst),
  .fetchExt      (fetchExt),
  .coreClkEn     (coreClkEn),
  .periphClkEn   (periphClkEn),
  .oscEn         (oscEn),
  .aleForceHigh  (aleForceHigh),
  .psenForceHigh (psenForceHigh),
  .port0Float    (port0Float)
);

// File: tb/rstLowPowerCtrl_tb_top.sv
module rstLowPowerCtrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IRQ_W      = 8;
  localparam int PC_W       = 16;
  localparam int ROM_WORDS  = 8192;
  localparam int RST_LEN    = 24;

  logic clk = 1'b0;
  logic porN, rstPin, extAccessPin, idleReq, pdReq, instrDone;
  logic [IRQ_W-1:0] irqPending;
  logic [PC_W-1:0]  pc;
  logic coreRst, fetchExt, coreClkEn, periphClkEn, oscEn;
  logic aleForceHigh, psenForceHigh, port0Float, modeClear;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rstLowPowerCtrl dut_i (
    .clk(clk), .porN(porN), .rstPin(rstPin), .extAccessPin(extAccessPin),
    .idleReq(idleReq), .pdReq(pdReq), .instrDone(instrDone),
    .irqPending(irqPending), .pc(pc), .coreRst(coreRst), .fetchExt(fetchExt),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn),
    .aleForceHigh(aleForceHigh), .psenForceHigh(psenForceHigh),
    .port0Float(port0Float), .modeClear(modeClear)
  );

  // 0 run, 1 idle, 2 power-down
  function automatic logic expFetch(logic ea, logic [PC_W-1:0] p);
    return !ea || (int'(p) >= ROM_WORDS);
  endfunction

  // {coreClkEn, periphClkEn, oscEn, ale, psen, port0Float, modeClear}
  function automatic logic [6:0] expOuts(int mode, logic fext, logic wake);
    case (mode)
      1:       return {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, fext, wake};
      2:       return {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, fext, wake};
      default: return {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, wake};
    endcase
  endfunction

  function automatic int nextMode(int mode, logic done, logic iReq, logic pReq,
                                  logic [IRQ_W-1:0] irq);
    if (mode == 0 && done && pReq) return 2;
    if (mode == 0 && done && iReq) return 1;
    if (mode == 1 && irq != '0)    return 0;
    return mode;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [6:0] actOuts();
    return {coreClkEn, periphClkEn, oscEn, aleForceHigh, psenForceHigh, port0Float, modeClear};
  endfunction

  // Pulse the reset pin for len cycles, then low for 8; returns whether reset was seen
  task automatic pulseRst(int len, output bit seen);
    seen = 1'b0;
    rstPin = 1'b1;
    for (int i = 0; i < len; i++) begin
      tick();
      seen |= coreRst;
    end
    rstPin = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      seen |= coreRst;
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    bit seen;
    int mode;
    logic wake;
    int pdCycles;
    void'($urandom(32'h1f2e3d4c));

    porN = 1'b0; rstPin = 1'b0; extAccessPin = 1'b1; idleReq = 1'b0;
    pdReq = 1'b0; instrDone = 1'b0; irqPending = '0; pc = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R2 power-on coreRst", coreRst, 1);
    check("R11 power-on modeClear", modeClear, 1);
    porN = 1'b1;
    tick(); tick(); tick();
    check("R2 release after power-on", coreRst, 0);
    check("R3 R4 strap high internal fetch", fetchExt, 0);

    // Exact threshold, strap captured during reset
    rstPin = 1'b1;
    for (int i = 0; i < 25; i++) begin
      tick();
      if (i == 9) extAccessPin = 1'b0;
    end
    check("R1 no reset after 25 edges", coreRst, 0);
    tick();
    check("R1 reset on edge 26", coreRst, 1);
    check("R11 modeClear during reset", modeClear, 1);
    tick(); tick(); tick(); tick();
    rstPin = 1'b0;
    tick(); tick();
    check("R2 still in reset two edges after low", coreRst, 1);
    tick();
    check("R2 released on third edge", coreRst, 0);
    extAccessPin = 1'b1;
    tick(); tick();
    pc = 16'd10;
    #1;
    check("R3 strap held low after release", fetchExt, 1);
    check("R4 strap low forces external", fetchExt, expFetch(1'b0, pc));

    // Back to strap high
    pulseRst(30, seen);
    check("R3 strap recaptured high", fetchExt, 0);

    pulseRst(23, seen);
    check("R1 23-cycle pulse ignored", seen, 0);
    pulseRst(24, seen);
    check("R1 24-cycle pulse accepted", seen, 1);
    rstPin = 1'b1;
    for (int i = 0; i < 20; i++) begin tick(); seen |= coreRst; end
    seen = 1'b0;
    rstPin = 1'b0;
    tick();
    rstPin = 1'b1;
    for (int i = 0; i < 20; i++) begin tick(); seen |= coreRst; end
    rstPin = 1'b0;
    for (int i = 0; i < 8; i++) begin tick(); seen |= coreRst; end
    check("R1 counter restarts on low gap", seen, 0);

    for (int k = 0; k < 8; k++) begin
      int len = $urandom_range(10, 40);
      pulseRst(len, seen);
      check("R1 random pulse length", seen, (len >= RST_LEN) ? 1 : 0);
    end

    // Fetch source, strap high
    pc = 16'd8191; #1; check("R4 pc 8191 internal", fetchExt, 0);
    pc = 16'd8192; #1; check("R4 pc 8192 external", fetchExt, 1);
    for (int k = 0; k < 10; k++) begin
      pc = PC_W'($urandom_range(0, 65535));
      #1;
      check("R4 random pc", fetchExt, expFetch(1'b1, pc));
    end
    extAccessPin = 1'b0;
    tick();
    pc = 16'd100; #1;
    check("R3 strap change outside reset ignored", fetchExt, 0);
    extAccessPin = 1'b1;

    // R10: requests without completion strobe
    pc = 16'd100;
    idleReq = 1'b1; pdReq = 1'b1;
    tick(); tick(); tick();
    check("R10 no entry without instrDone", actOuts(), expOuts(0, 1'b0, 1'b0));
    pdReq = 1'b0;
    instrDone = 1'b1;
    tick();
    instrDone = 1'b0;
    check("R5 R8 idle internal memory", actOuts(), expOuts(1, 1'b0, 1'b0));
    pc = 16'd9000; #1;
    check("R8 idle port0 floats for external fetch", port0Float, 1);
    tick();
    irqPending = 8'h20;
    tick();
    irqPending = '0;
    check("R6 wake on interrupt", actOuts(), expOuts(0, 1'b0, 1'b1));
    idleReq = 1'b0;
    tick();
    check("R6 modeClear single cycle", modeClear, 0);

    // R7 power-down
    pdReq = 1'b1; instrDone = 1'b1;
    tick();
    instrDone = 1'b0;
    check("R7 power-down outputs", actOuts(), expOuts(2, 1'b1, 1'b0));
    irqPending = 8'hff;
    tick(); tick();
    irqPending = '0;
    check("R7 interrupt ignored in power-down", oscEn, 0);
    pulseRst(30, seen);
    pdReq = 1'b0;
    check("R7 R11 reset ends power-down", actOuts(), expOuts(0, 1'b0, 1'b0));

    // R9 both requests
    idleReq = 1'b1; pdReq = 1'b1; instrDone = 1'b1;
    tick();
    instrDone = 1'b0;
    check("R9 power-down wins", actOuts(), expOuts(2, 1'b1, 1'b0));
    pulseRst(30, seen);
    idleReq = 1'b0; pdReq = 1'b0;

    // R11 reset ends idle
    idleReq = 1'b1; instrDone = 1'b1;
    tick();
    instrDone = 1'b0;
    check("R5 idle entry", coreClkEn, 0);
    pulseRst(30, seen);
    idleReq = 1'b0;
    check("R11 reset ends idle", coreClkEn, 1);

    // Random mode stream
    mode = 0; wake = 1'b0; pdCycles = 0;
    for (int k = 0; k < 400; k++) begin
      int nm;
      logic nw;
      pc = PC_W'($urandom_range(0, 65535));
      instrDone = ($urandom_range(0, 1) == 1);
      if (mode == 0) begin
        idleReq = ($urandom_range(0, 3) == 0);
        pdReq   = ($urandom_range(0, 9) == 0);
        irqPending = IRQ_W'($urandom_range(0, 255));
      end else if (mode == 1) begin
        irqPending = ($urandom_range(0, 4) == 0) ? IRQ_W'(1 << $urandom_range(0, IRQ_W - 1)) : '0;
      end else begin
        irqPending = IRQ_W'($urandom_range(0, 255));
        pdCycles++;
      end
      if (mode == 2 && pdCycles > 6) begin
        instrDone = 1'b0; irqPending = '0;
        pulseRst(30, seen);
        idleReq = 1'b0; pdReq = 1'b0;
        mode = 0; wake = 1'b0; pdCycles = 0;
        check("R7 R11 random power-down exit by reset", actOuts(),
              expOuts(0, 1'b0, 1'b0));
      end else begin
        nm = nextMode(mode, instrDone, idleReq, pdReq, irqPending);
        nw = (mode == 1) && (irqPending != '0);
        tick();
        mode = nm; wake = nw;
        check("R5 R6 R7 R8 R9 random mode stream", actOuts(),
              expOuts(mode, expFetch(1'b1, pc), wake));
      end
    end

    instrDone = 1'b0; idleReq = 1'b0; pdReq = 1'b0; irqPending = '0;
    finishRun();
  end

endmodule